// File: doc/BRIEF.md
# Fully Associative Block Cache

This block holds up to 64 cached 32-byte blocks, any of which may sit in any entry. The 32-bit address is split into a 27-bit tag (bits 31..5) and a 5-bit byte offset (bits 4..0). There is no set index. A lookup compares the tag against every valid stored tag in the same cycle. It returns a hit flag, the binary number of the matching entry and the matching entry's 256-bit block, all combinationally.

A fill port writes a whole block and its tag into the entry named by `victim_idx_o`. While some entries are still empty, the victim is the lowest-numbered empty entry. Once every entry is valid, the victim comes from a single rotating replacement pointer. This pointer gives a cheap approximation of least-recently-used. It steps to the next entry only when the entry it names is accessed, by a lookup hit or a fill, and it wraps from the last entry back to entry 0. Write policy and memory sequencing sit outside the block. A fill is only issued for a tag that is not already stored.

Top module: `fa_cache`

## Requirements
- R1: After reset no entry is valid. A valid lookup misses and `victim_idx_o` is 0.
- R2: Matching uses address bits 31..5 only. Lookups that differ only in bits 4..0 give the same result.
- R3: On a lookup whose tag is stored, `hit_o` is 1 in the same cycle. `hit_idx_o` gives the entry number in binary and `hit_data_o` gives the block last filled into that entry.
- R4: A lookup whose tag is not stored in any valid entry gives `hit_o` = 0.
- R5: While any entry is invalid, `victim_idx_o` names the lowest-numbered invalid entry. A fill writes the block and tag there and makes that entry valid.
- R6: When all entries are valid, `victim_idx_o` equals the replacement pointer. A fill writes that entry and advances the pointer by one.
- R7: A lookup hit on the entry the pointer names advances the pointer by one. A hit on any other entry, or a miss, leaves the pointer unchanged.
- R8: The pointer advances from entry 63 to entry 0.
- R9: After a fill replaces an entry, the evicted tag misses and the new tag hits in that entry.
- R10: With `lookup_valid_i` low, `hit_o` is 0 and the pointer does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lookup_valid_i | input | 1 | Lookup request this cycle |
| lookup_addr_i | input | 32 | Lookup byte address |
| hit_o | output | 1 | Lookup matched a valid entry |
| hit_idx_o | output | 6 | Matching entry number |
| hit_data_o | output | 256 | Block held in the matching entry |
| fill_valid_i | input | 1 | Write a block into the victim entry this cycle |
| fill_addr_i | input | 32 | Address of the block being filled |
| fill_data_i | input | 256 | Block being filled |
| victim_idx_o | output | 6 | Entry the next fill will write |

## Verification
Lookups are run with the same tag under different byte offsets, with tags that differ only in their lowest tag bit, and with the all-ones tag. These separate true tag matching from offset leakage and from partial comparison. Fills into an empty cache, and then into a full cache, show the lowest-empty rule apart from the pointer rule. Lookup hits are placed on the pointed entry and on other entries. This distinguishes a pointer that steps only on its own entry from one that moves on any hit. A run of hits on the pointed entry carries the pointer past entry 63 so that the wrap is observed.

// File: rtl/fa_cache_pkg.sv
package fa_cache_pkg;
  localparam int unsigned ADDR_W_DEF  = 32;
  localparam int unsigned OFFS_W_DEF  = 5;
  localparam int unsigned ENTRIES_DEF = 64;
endpackage

// File: rtl/fa_tag_match.sv
module fa_tag_match #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned TAG_W   = 27,
  parameter int unsigned IDX_W   = 6
) (
  input  logic [TAG_W-1:0] tags_i [ENTRIES],
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic [ENTRIES-1:0] match_o,
  output logic               hit_o,
  output logic [IDX_W-1:0]   hit_idx_o
);
  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign match_o[e] = valid_i[e] && (tags_i[e] == tag_i);
  end

  assign hit_o = |match_o;

  // one-hot to binary: OR of entry numbers whose comparator fired
  always_comb begin
    hit_idx_o = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (match_o[e]) hit_idx_o = hit_idx_o | IDX_W'(e);
    end
  end
endmodule

// File: rtl/fa_victim_sel.sv
module fa_victim_sel #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned IDX_W   = 6
) (
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [IDX_W-1:0]   ptr_i,
  output logic [IDX_W-1:0]   victim_o
);
  // descending scan: last assignment wins, giving the lowest free entry
  always_comb begin
    victim_o = ptr_i;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (!valid_i[e]) victim_o = IDX_W'(e);
    end
  end
endmodule

// File: rtl/fa_repl_ptr.sv
module fa_repl_ptr #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned IDX_W   = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [IDX_W-1:0] ptr_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_o <= '0;
    else if (adv_i) ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
  end
endmodule

// File: rtl/fa_cache.sv
module fa_cache
  import fa_cache_pkg::*;
#(
  parameter int unsigned ADDR_W  = ADDR_W_DEF,
  parameter int unsigned OFFS_W  = OFFS_W_DEF,
  parameter int unsigned ENTRIES = ENTRIES_DEF,
  localparam int unsigned TAG_W  = ADDR_W - OFFS_W,
  localparam int unsigned DATA_W = 8 * (2 ** OFFS_W),
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lookup_valid_i,
  input  logic [ADDR_W-1:0] lookup_addr_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  hit_idx_o,
  output logic [DATA_W-1:0] hit_data_o,
  input  logic              fill_valid_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  input  logic [DATA_W-1:0] fill_data_i,
  output logic [IDX_W-1:0]  victim_idx_o
);
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [DATA_W-1:0]  data_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] match_vec;
  logic               any_match;
  logic [IDX_W-1:0]   match_idx;
  logic [IDX_W-1:0]   ptr_q;
  logic               ptr_adv;

  fa_tag_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_match (
    .tags_i   (tag_q),
    .valid_i  (valid_q),
    .tag_i    (lookup_addr_i[ADDR_W-1:OFFS_W]),
    .match_o  (match_vec),
    .hit_o    (any_match),
    .hit_idx_o(match_idx)
  );

  fa_victim_sel #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .valid_i (valid_q),
    .ptr_i   (ptr_q),
    .victim_o(victim_idx_o)
  );

  // pointer steps when its own entry is touched by a hit or a fill
  assign ptr_adv = (lookup_valid_i && any_match && (match_idx == ptr_q)) ||
                   (fill_valid_i && (victim_idx_o == ptr_q));

  fa_repl_ptr #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_ptr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (ptr_adv),
    .ptr_o (ptr_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           valid_q <= '0;
    else if (fill_valid_i) valid_q[victim_idx_o] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (fill_valid_i) begin
      tag_q[victim_idx_o]  <= fill_addr_i[ADDR_W-1:OFFS_W];
      data_q[victim_idx_o] <= fill_data_i;
    end
  end

  assign hit_o     = lookup_valid_i && any_match;
  assign hit_idx_o = match_idx;

  always_comb begin
    hit_data_o = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (match_vec[e]) hit_data_o = hit_data_o | data_q[e];
    end
  end
endmodule

// File: rtl/fa_cache_sva.sv
module fa_cache_sva #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned IDX_W   = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               lookup_valid_i,
  input logic               fill_valid_i,
  input logic               hit_o,
  input logic [IDX_W-1:0]   hit_idx_o,
  input logic [IDX_W-1:0]   victim_idx_o,
  input logic [IDX_W-1:0]   ptr_q,
  input logic [ENTRIES-1:0] valid_q,
  input logic [ENTRIES-1:0] match_vec
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  p_hit_needs_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> lookup_valid_i);

  p_single_match_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match_vec));

  p_ptr_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && hit_idx_o == ptr_q && !fill_valid_i) |=>
      ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + 1'b1));

  p_ptr_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fill_valid_i && !(hit_o && hit_idx_o == ptr_q)) |=> $stable(ptr_q));

  p_fill_grows_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && !(&valid_q)) |=>
      $countones(valid_q) == $countones($past(valid_q)) + 1);

  p_full_victim_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&valid_q) |-> victim_idx_o == ptr_q);
endmodule

bind fa_cache fa_cache_sva #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_sva (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .lookup_valid_i(lookup_valid_i),
  .fill_valid_i  (fill_valid_i),
  .hit_o         (hit_o),
  .hit_idx_o     (hit_idx_o),
  .victim_idx_o  (victim_idx_o),
  .ptr_q         (ptr_q),
  .valid_q       (valid_q),
  .match_vec     (match_vec)
);

// File: tb/fa_cache_test.sv
module fa_cache_test;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         lookup_valid_i = 1'b0;
  logic [31:0]  lookup_addr_i = '0;
  logic         hit_o;
  logic [5:0]   hit_idx_o;
  logic [255:0] hit_data_o;
  logic         fill_valid_i = 1'b0;
  logic [31:0]  fill_addr_i = '0;
  logic [255:0] fill_data_i = '0;
  logic [5:0]   victim_idx_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk_i = ~clk_i;

  fa_cache uut (.*);

  typedef struct packed {
    logic        fill;
    logic [31:0] addr;
    logic        exp_hit;
    logic [5:0]  exp_idx;   // hit entry, or victim before a fill
    logic [5:0]  exp_vic;   // victim after the edge
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{1'b1, 32'h0000_1000, 1'b0, 6'd0, 6'd1},
    '{1'b1, 32'h0000_2000, 1'b0, 6'd1, 6'd2},
    '{1'b1, 32'h0000_3000, 1'b0, 6'd2, 6'd3},
    '{1'b0, 32'h0000_101F, 1'b1, 6'd0, 6'd3},
    '{1'b0, 32'h0000_2004, 1'b1, 6'd1, 6'd3},
    '{1'b0, 32'h0000_4000, 1'b0, 6'd0, 6'd3},
    '{1'b0, 32'h0000_3000, 1'b1, 6'd2, 6'd3},
    '{1'b1, 32'hFFFF_FFE0, 1'b0, 6'd3, 6'd4},
    '{1'b0, 32'hFFFF_FFFF, 1'b1, 6'd3, 6'd4},
    '{1'b0, 32'h0000_1020, 1'b0, 6'd0, 6'd4}
  };

  function automatic logic [255:0] blk_of(input logic [31:0] a);
    return {8{a[31:5] ^ 27'h2A5_C3E1, 5'b10110}};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  logic         s_hit;
  logic [5:0]   s_idx;
  logic [255:0] s_data;
  logic [5:0]   s_vb;
  logic [5:0]   s_va;

  task automatic step(input logic f, input logic lv, input logic [31:0] a);
    @(negedge clk_i);
    fill_valid_i   = f;
    fill_addr_i    = a;
    fill_data_i    = blk_of(a);
    lookup_valid_i = lv;
    lookup_addr_i  = a;
    #1;
    s_hit = hit_o; s_idx = hit_idx_o; s_data = hit_data_o; s_vb = victim_idx_o;
    @(posedge clk_i);
    #1;
    fill_valid_i = 1'b0;
    lookup_valid_i = 1'b0;
    s_va = victim_idx_o;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  logic [31:0] addr_m [64];

  initial begin
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1'b1;
    // R1 reset state
    step(1'b0, 1'b1, 32'h0000_0000);
    chk("R1", "hit after reset", 256'(s_hit), 256'(0));
    chk("R1", "victim after reset", 256'(s_va), 256'(0));

    // vector table: R2 R3 R4 R5 fills and lookups
    for (int i = 0; i < 10; i++) begin
      step(VECS[i].fill, !VECS[i].fill, VECS[i].addr);
      if (VECS[i].fill) begin
        chk("R5", $sformatf("vec%0d fill victim", i), 256'(s_vb), 256'(VECS[i].exp_idx));
        addr_m[VECS[i].exp_idx] = VECS[i].addr;
      end else begin
        chk(VECS[i].exp_hit ? "R2" : "R4", $sformatf("vec%0d hit", i),
            256'(s_hit), 256'(VECS[i].exp_hit));
        if (VECS[i].exp_hit) begin
          chk("R3", $sformatf("vec%0d idx", i), 256'(s_idx), 256'(VECS[i].exp_idx));
          chk("R3", $sformatf("vec%0d data", i), s_data, blk_of(VECS[i].addr));
        end
      end
      chk("R7", $sformatf("vec%0d victim after", i), 256'(s_va), 256'(VECS[i].exp_vic));
    end

    // fill the rest: lowest free entry each time (R5)
    for (int i = 4; i < 64; i++) begin
      addr_m[i] = (32'h100 + 32'(i)) << 5;
      step(1'b1, 1'b0, addr_m[i]);
      chk("R5", $sformatf("fill victim %0d", i), 256'(s_vb), 256'(i));
    end
    chk("R6", "full victim is pointer 0", 256'(s_va), 256'(0));

    // R7 hit off the pointer keeps it
    step(1'b0, 1'b1, addr_m[5]);
    chk("R3", "hit idx 5", 256'(s_idx), 256'(5));
    chk("R7", "pointer kept on other hit", 256'(s_va), 256'(0));
    // R10 idle lookup
    step(1'b0, 1'b0, addr_m[0]);
    chk("R10", "no hit without valid", 256'(s_hit), 256'(0));
    chk("R10", "pointer kept when idle", 256'(s_va), 256'(0));
    // R7 hit on pointer advances it
    step(1'b0, 1'b1, addr_m[0]);
    chk("R7", "pointer advanced", 256'(s_va), 256'(1));
    // R6 fill replaces pointed entry
    step(1'b1, 1'b0, 32'hABCD_0040);
    chk("R6", "full fill victim", 256'(s_vb), 256'(1));
    chk("R6", "pointer after fill", 256'(s_va), 256'(2));
    addr_m[1] = 32'hABCD_0040;
    // R9 evicted tag misses, new tag hits
    step(1'b0, 1'b1, 32'h0000_2000);
    chk("R9", "evicted tag misses", 256'(s_hit), 256'(0));
    step(1'b0, 1'b1, 32'hABCD_005C);
    chk("R9", "new tag hit", 256'(s_hit), 256'(1));
    chk("R9", "new tag idx", 256'(s_idx), 256'(1));
    chk("R9", "new tag data", s_data, blk_of(32'hABCD_0040));

    // R8 walk pointer to the end and across the wrap
    for (int i = 2; i < 64; i++) begin
      step(1'b0, 1'b1, addr_m[i]);
      if (!s_hit) chk("R7", $sformatf("walk hit %0d", i), 256'(s_hit), 256'(1));
    end
    chk("R8", "pointer wrapped to 0", 256'(s_va), 256'(0));
    step(1'b1, 1'b0, 32'h7777_7700);
    chk("R8", "fill after wrap uses 0", 256'(s_vb), 256'(0));
    finish_run();
  end
endmodule